// File: doc/BRIEF.md
# SMI Feature Negotiator and APM Command Dispatcher

This block lets firmware agree on a set of system-management-interrupt features with the platform, then turns writes to the APM command port into SMI requests. Firmware writes a 64-bit request one byte at a time through a byte-wide register port and then writes a trigger register. The block checks the request against a host-supported mask set by a parameter, and against the dependencies between features. If every check passes, the request is copied into the negotiated set and a sticky ok flag is raised. After that, the negotiated set cannot change until reset.

A write to the APM command port does one of two things. If the value is the ACPI-on or ACPI-off command, the block emits a one-cycle strobe for that command. Any other value raises SMI, but only when the APM-command SMI enable input is high. The SMI goes either to the current CPU or to every CPU, depending on whether the broadcast feature was negotiated. All outputs are registered and respond one clock after the write is sampled.

Top module: `smi_negotiator`

## Requirements
- R1: Synchronous reset clears the request bytes, the ok flag, the negotiated set and every output. A trigger written right after reset, with no request bytes written, succeeds with a negotiated set of zero.
- R2: A write to address A, for A from 0 to 7, stores the data byte into request bits 8A+7 down to 8A (little-endian).
- R3: A trigger write (address 8) fails and leaves the ok flag at 0 if the request holds any bit that is clear in the host mask.
- R4: A trigger write fails if the request holds the hotplug bit or the hot-unplug bit but not the broadcast bit. The default bit positions are broadcast = bit 0, hotplug = bit 1, hot-unplug = bit 2.
- R5: A trigger write fails if the request holds the hot-unplug bit without the hotplug bit.
- R6: A trigger write on a valid request sets the ok flag to 1 and makes the negotiated set equal to the request. Both are visible one clock after the write.
- R7: Once the ok flag is 1, later trigger writes and request-byte writes leave the ok flag and the negotiated set unchanged.
- R8: An APM write (address 9) whose data equals the ACPI-on command (default 0xF0) or the ACPI-off command (default 0xF1) pulses only that strobe, for one cycle. It raises no SMI, whatever the enable input is.
- R9: An APM write with any other value raises no SMI and no strobe while the SMI enable input is low.
- R10: With the enable input high and broadcast negotiated, any other APM value pulses every per-CPU SMI line in the same single cycle.
- R11: With the enable input high and broadcast not negotiated, any other APM value pulses only the SMI line selected by the current-CPU input, for one cycle.
- R12: A failed trigger does not lock the block, so a later trigger on a valid request still succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0-7 request bytes, 8 trigger, 9 APM command |
| wr_data | input | 8 | Write data byte |
| apmc_en | input | 1 | SMI enable for APM command writes |
| cur_cpu | input | CPU_W | Index of the CPU issuing the write |
| smi_out | output | NUM_CPUS | Per-CPU SMI pulses |
| acpi_on | output | 1 | ACPI-enable command strobe |
| acpi_off | output | 1 | ACPI-disable command strobe |
| feat_ok | output | 1 | Negotiation succeeded, set is locked |
| feat_neg | output | FEAT_W | Negotiated feature set |

## Verification
The bench targets the feature-dependency rules. It sends hot-unplug alone, hotplug without broadcast, and an unsupported bit placed beside valid ones. A validator that dropped any one rule would raise the ok flag on one of these requests. It also writes a new request and triggers again after a success: a design without the lock would overwrite the negotiated set. On the APM side, the bench checks that the ACPI commands never raise SMI even with the enable input high, and that a request without broadcast reaches only the selected CPU. A wrong decoder would fire SMI on a command value, or pulse the wrong CPU lines.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int REG_ADDR_W = 4;
  localparam int BYTE_W     = 8;
  localparam logic [REG_ADDR_W-1:0] ADDR_TRIG = 4'd8;
  localparam logic [REG_ADDR_W-1:0] ADDR_APM  = 4'd9;

  typedef enum logic [1:0] {
    APM_IDLE,
    APM_ACPI_ON,
    APM_ACPI_OFF,
    APM_RAISE
  } apm_kind_t;
endpackage

// File: rtl/smi_req_reg.sv
module smi_req_reg
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W = 64,
  localparam int NBYTES = FEAT_W / BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [FEAT_W-1:0]     req
);
  logic [BYTE_W-1:0] byte_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) byte_q[b] <= '0;
      else if (wr_en && wr_addr == REG_ADDR_W'(b)) byte_q[b] <= wr_data;
    end
    assign req[b*BYTE_W +: BYTE_W] = byte_q[b];

    // R2
    byte_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == REG_ADDR_W'(b)) |=> (req[b*BYTE_W +: BYTE_W] == $past(wr_data)));
  end
endmodule

// File: rtl/smi_feat_check.sv
module smi_feat_check #(
  parameter int               FEAT_W    = 64,
  parameter logic [FEAT_W-1:0] HOST_MASK = 64'h7,
  parameter int               BCAST_BIT = 0,
  parameter int               HP_BIT    = 1,
  parameter int               HU_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [FEAT_W-1:0] req,
  output logic              ok_q,
  output logic [FEAT_W-1:0] neg_q
);
  logic unsupported, needs_bcast, orphan_unplug, accept;

  always_comb begin
    unsupported   = |(req & ~HOST_MASK);
    needs_bcast   = (req[HP_BIT] | req[HU_BIT]) & ~req[BCAST_BIT];
    orphan_unplug = req[HU_BIT] & ~req[HP_BIT];
    accept        = trig & ~ok_q & ~unsupported & ~needs_bcast & ~orphan_unplug;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      neg_q <= '0;
    end else if (accept) begin
      ok_q  <= 1'b1;
      neg_q <= req;
    end
  end

  // R7
  ok_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ok_q |=> ok_q);
  // R7
  neg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ok_q |=> $stable(neg_q));
  // R3
  neg_in_host_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> ((neg_q & ~HOST_MASK) == '0));
  // R4
  hotplug_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_q && (neg_q[HP_BIT] || neg_q[HU_BIT])) |-> neg_q[BCAST_BIT]);
  // R5
  unplug_dep_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_q && neg_q[HU_BIT]) |-> neg_q[HP_BIT]);
  // R6
  ok_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> $past(trig));
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch
  import smi_neg_pkg::*;
#(
  parameter int               NUM_CPUS = 4,
  parameter logic [BYTE_W-1:0] ON_CMD   = 8'hF0,
  parameter logic [BYTE_W-1:0] OFF_CMD  = 8'hF1,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                apm_wr,
  input  logic [BYTE_W-1:0]   apm_val,
  input  logic                apmc_en,
  input  logic                bcast,
  input  logic [CPU_W-1:0]    cur_cpu,
  output logic [NUM_CPUS-1:0] smi_q,
  output logic                acpi_on_q,
  output logic                acpi_off_q
);
  apm_kind_t           kind;
  logic [NUM_CPUS-1:0] target;

  always_comb begin
    if (!apm_wr)                kind = APM_IDLE;
    else if (apm_val == ON_CMD)  kind = APM_ACPI_ON;
    else if (apm_val == OFF_CMD) kind = APM_ACPI_OFF;
    else                         kind = APM_RAISE;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_tgt
    assign target[c] = bcast | (cur_cpu == CPU_W'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_q      <= '0;
      acpi_on_q  <= 1'b0;
      acpi_off_q <= 1'b0;
    end else begin
      acpi_on_q  <= (kind == APM_ACPI_ON);
      acpi_off_q <= (kind == APM_ACPI_OFF);
      smi_q      <= (kind == APM_RAISE && apmc_en) ? target : '0;
    end
  end

  // R8
  cmd_no_smi_chk: assert property (@(posedge clk) disable iff (rst)
    (acpi_on_q || acpi_off_q) |-> (smi_q == '0));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(acpi_on_q && acpi_off_q));
  // R9
  gated_smi_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && !apmc_en) |=> (smi_q == '0));
  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && !bcast) |=> ($countones(smi_q) <= 1));
  // R10
  bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && bcast && apmc_en && apm_val != ON_CMD && apm_val != OFF_CMD)
      |=> (smi_q == '1));
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
  import smi_neg_pkg::*;
#(
  parameter int               FEAT_W    = 64,
  parameter logic [FEAT_W-1:0] HOST_MASK = 64'h7,
  parameter int               BCAST_BIT = 0,
  parameter int               HP_BIT    = 1,
  parameter int               HU_BIT    = 2,
  parameter int               NUM_CPUS  = 4,
  parameter logic [7:0]       ON_CMD    = 8'hF0,
  parameter logic [7:0]       OFF_CMD   = 8'hF1,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [3:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                apmc_en,
  input  logic [CPU_W-1:0]    cur_cpu,
  output logic [NUM_CPUS-1:0] smi_out,
  output logic                acpi_on,
  output logic                acpi_off,
  output logic                feat_ok,
  output logic [FEAT_W-1:0]   feat_neg
);
  logic [FEAT_W-1:0] req;
  logic trig, apm_wr;

  assign trig   = wr_en && (wr_addr == ADDR_TRIG);
  assign apm_wr = wr_en && (wr_addr == ADDR_APM);

  smi_req_reg #(.FEAT_W(FEAT_W)) u_req (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req)
  );

  smi_feat_check #(
    .FEAT_W(FEAT_W), .HOST_MASK(HOST_MASK),
    .BCAST_BIT(BCAST_BIT), .HP_BIT(HP_BIT), .HU_BIT(HU_BIT)
  ) u_chk (
    .clk(clk), .rst(rst), .trig(trig), .req(req),
    .ok_q(feat_ok), .neg_q(feat_neg)
  );

  smi_apm_dispatch #(
    .NUM_CPUS(NUM_CPUS), .ON_CMD(ON_CMD), .OFF_CMD(OFF_CMD)
  ) u_apm (
    .clk(clk), .rst(rst), .apm_wr(apm_wr), .apm_val(wr_data),
    .apmc_en(apmc_en), .bcast(feat_neg[BCAST_BIT]), .cur_cpu(cur_cpu),
    .smi_q(smi_out), .acpi_on_q(acpi_on), .acpi_off_q(acpi_off)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!feat_ok && feat_neg == '0 && smi_out == '0 && !acpi_on && !acpi_off));
endmodule

// File: tb/smi_negotiator_tb.sv
module smi_negotiator_tb;
  localparam logic [63:0] HOST = 64'h8000_0100_0000_0007;
  localparam int NCPU = 4;
  localparam logic [7:0] ONC = 8'hF0, OFFC = 8'hF1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic apmc_en = 1'b0;
  logic [1:0] cur_cpu = '0;
  logic [NCPU-1:0] smi_out;
  logic acpi_on, acpi_off, feat_ok;
  logic [63:0] feat_neg;

  int n_total = 0, n_bad = 0;
  bit done = 0;
  logic m_ok;
  logic [63:0] m_req, m_neg;

  always #2 clk = ~clk;

  smi_negotiator #(.HOST_MASK(HOST), .NUM_CPUS(NCPU)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .apmc_en(apmc_en), .cur_cpu(cur_cpu), .smi_out(smi_out),
    .acpi_on(acpi_on), .acpi_off(acpi_off), .feat_ok(feat_ok), .feat_neg(feat_neg)
  );

  function automatic logic valid_req(input logic [63:0] r);
    if ((r & ~HOST) != 0) return 1'b0;
    if ((r[1] || r[2]) && !r[0]) return 1'b0;
    if (r[2] && !r[1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4'd8) m_req[a*8 +: 8] = d;
    else if (a == 4'd8 && !m_ok && valid_req(m_req)) begin
      m_ok = 1'b1; m_neg = m_req;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_ok = 1'b0; m_req = '0; m_neg = '0;
  endtask

  task automatic load_req(input logic [63:0] r);
    for (int b = 0; b < 8; b++) wr(4'(b), r[b*8 +: 8]);
  endtask

  task automatic negotiate(input string tag, input logic [63:0] r);
    load_req(r);
    wr(4'd8, 8'h00);
    chk({tag, " ok"}, 64'(feat_ok), 64'(m_ok));
    chk({tag, " neg"}, feat_neg, m_neg);
  endtask

  task automatic apm(input string tag, input logic [7:0] v, input logic en, input logic [1:0] cpu);
    logic [NCPU-1:0] es;
    apmc_en = en; cur_cpu = cpu;
    wr(4'd9, v);
    es = '0;
    if (v != ONC && v != OFFC && en) es = m_neg[0] ? '1 : NCPU'(1) << cpu;
    chk({tag, " smi"}, 64'(smi_out), 64'(es));
    chk({tag, " on"}, 64'(acpi_on), 64'(v == ONC));
    chk({tag, " off"}, 64'(acpi_off), 64'(v == OFFC));
    @(negedge clk);
    chk({tag, " pulse end"}, 64'({smi_out, acpi_on, acpi_off}), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd7321));
    m_ok = 1'b0; m_req = '0; m_neg = '0;
    do_reset();
    // R1 reset state
    chk("R1 ok", 64'(feat_ok), 64'd0);
    chk("R1 neg", feat_neg, 64'd0);
    chk("R1 outs", 64'({smi_out, acpi_on, acpi_off}), 64'd0);
    // R3 unsupported bit
    negotiate("R3", 64'h27);
    // R4 hotplug without broadcast
    negotiate("R4 hp", 64'h02);
    negotiate("R4 hu", 64'h06);
    // R5 unplug without hotplug
    negotiate("R5", 64'h05);
    // R12 R6 R2 valid request after failures, high bytes
    negotiate("R12 R6 R2", HOST);
    chk("R6 ok set", 64'(feat_ok), 64'd1);
    // R7 locked
    negotiate("R7", 64'h01);
    chk("R7 neg held", feat_neg, HOST);
    // R8 commands
    apm("R8 on", ONC, 1'b1, 2'd1);
    apm("R8 off", OFFC, 1'b1, 2'd3);
    // R9 gated
    apm("R9", 8'h33, 1'b0, 2'd0);
    // R10 broadcast
    apm("R10", 8'h42, 1'b1, 2'd1);
    // R1 reset clears the request bytes
    do_reset();
    chk("R1 ok after rst", 64'(feat_ok), 64'd0);
    wr(4'd8, 8'h00);
    chk("R1 cleared req ok", 64'(feat_ok), 64'd1);
    chk("R1 cleared req neg", feat_neg, 64'd0);
    // R11 single target
    apm("R11", 8'h10, 1'b1, 2'd2);
    // random rounds
    for (int i = 0; i < 40; i++) begin
      do_reset();
      r = {$urandom, $urandom} & HOST;
      if ($urandom_range(0, 3) == 0) r[$urandom_range(0, 63)] = 1'b1;
      negotiate("R3 R4 R5 R6 rnd", r);
      for (int k = 0; k < 5; k++) begin
        logic [7:0] v;
        case ($urandom_range(0, 3))
          0: v = ONC;
          1: v = OFFC;
          default: v = 8'($urandom);
        endcase
        apm("R8 R9 R10 R11 rnd", v, 1'($urandom), 2'($urandom));
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule